// File: doc/BRIEF.md
# Framed Full-Duplex Serial Port

This block is a synchronous serial port that carries bytes both ways at once between a host and a five-wire link. The five wires are a serial clock, an outgoing data line, an incoming data line, an outgoing-direction frame strobe and an incoming-direction frame strobe. The port either generates the serial clock and both frame strobes itself (master), or follows a clock and strobes driven by the far end (slave). In slave mode the clock and strobes are resynchronised into the system clock domain. Their edges are then detected there.

The host side is two streams that share one data path: half-words written into the transmit stream, and half-words read from the receive stream. Each side has a 16-entry half-word queue. Every half-word travels as two bytes on the wire. A one-period frame strobe comes before each byte. Two level interrupts report when the transmit queue has room for half of its depth and when the receive queue holds half of its depth. Two sticky flags record a starved transmitter and a dropped receive word. Reading status clears both flags.

Back-pressure works as follows. A transmit word is taken on any cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is low only while the transmit queue is full. `rx_valid` stays high while the receive queue holds a word, and `rx_data` shows the oldest one. That word leaves on a cycle where `rx_valid` and `rx_ready` are both high. The serial link cannot be stalled: when a queue cannot keep up, the port fills in or drops data as described below.

Top module: `framed_serial_port`

## Requirements
- R1: The output enables `sclk_oe`, `txfs_oe` and `rxfs_oe` are 1 in master mode (`cfg_master`=1) and 0 in slave mode. `txd_out` is always driven.
- R2: In master mode with either side enabled, `sclk_out` toggles every CLK_HALF system cycles, giving a rising edge every 2*CLK_HALF cycles. With both sides disabled, `sclk_out` is low one cycle later.
- R3: Each byte slot lasts nine serial periods. In the first period the frame strobe is high. It is low during the next eight periods, which carry the data bits most significant bit first. Of each half-word, bits 15:8 are sent before bits 7:0.
- R4: In master mode, with `txd_out` looped back to `rxd_in`, the half-words written arrive on the receive stream unchanged and in order.
- R5: When a byte is due and the transmit queue has no pending byte, the port sends 0x00 and sets `stat_underrun`.
- R6: When a received half-word completes while the receive queue holds 16 words, that word is discarded, the 16 stored words are kept, and `stat_overrun` is set.
- R7: `stat_underrun` and `stat_overrun` stay set until a cycle with `stat_rd`=1, and are low after it unless a new event occurs in that same cycle.
- R8: `irq_tx` is 1 exactly when `cfg_tx_en`=1 and the transmit queue holds 8 or fewer words.
- R9: `irq_rx` is 1 exactly when `cfg_rx_en`=1 and the receive queue holds 8 or more words.
- R10: In slave mode, outgoing bits change after rising edges of `sclk_in` and incoming bits are sampled on falling edges. A byte starts after a falling edge at which the matching frame input is high.
- R11: With `cfg_tx_en`=0, `txd_out` is 0 and the transmit queue is not drained. With `cfg_rx_en`=0, nothing is written into the receive queue.
- R12: The transmit queue accepts at most 16 words. `tx_ready` is 0 while it is full, and a write offered then is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1: port drives clock and frame strobes |
| cfg_tx_en | input | 1 | Enables the transmit side |
| cfg_rx_en | input | 1 | Enables the receive side |
| tx_valid | input | 1 | Host offers a transmit half-word |
| tx_ready | output | 1 | Transmit queue can take a word |
| tx_data | input | 16 | Transmit half-word |
| rx_valid | output | 1 | Receive queue holds a word |
| rx_ready | input | 1 | Host takes the shown word |
| rx_data | output | 16 | Oldest received half-word |
| stat_rd | input | 1 | Status read strobe, clears sticky flags |
| stat_underrun | output | 1 | Sticky: transmitter was starved |
| stat_overrun | output | 1 | Sticky: received word dropped |
| irq_tx | output | 1 | Transmit queue at most half full |
| irq_rx | output | 1 | Receive queue at least half full |
| sclk_in | input | 1 | Serial clock from the far end (slave) |
| sclk_out | output | 1 | Generated serial clock (master) |
| sclk_oe | output | 1 | Drive enable for the clock pin |
| txd_out | output | 1 | Outgoing serial data |
| rxd_in | input | 1 | Incoming serial data |
| txfs_in | input | 1 | Outgoing-direction frame strobe input (slave) |
| txfs_out | output | 1 | Outgoing-direction frame strobe (master) |
| txfs_oe | output | 1 | Drive enable for that strobe pin |
| rxfs_in | input | 1 | Incoming-direction frame strobe input (slave) |
| rxfs_out | output | 1 | Incoming-direction frame strobe (master) |
| rxfs_oe | output | 1 | Drive enable for that strobe pin |

## Verification
The hardest state to reach is a receive overrun in which the seventeenth completed half-word must disappear while the sixteen stored words survive intact. The link never pauses, so the stimulus gets there through the master loopback with the transmit side switched off. The link then keeps delivering zero words while the reader holds `rx_ready` low. Afterwards exactly sixteen words are drained. A second route runs in slave mode: the bench, acting as the far-end clock master, clocks two bytes past a full receive queue and an empty transmit queue. This hits underrun and overrun in the same word, and confirms that a write offered to the full transmit queue never shows up on the wire.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 2 * BYTE_W;
  // one strobe period followed by one period per data bit
  localparam int SLOT_PERIODS = BYTE_W + 1;
  typedef logic [HALF_W-1:0] half_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/fsp_fifo.sv
module fsp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          full,
  output logic          empty,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == LW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rptr];
  assign level   = cnt;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= step(wptr);
      if (do_pop)  rptr <= step(rptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/fsp_timing.sv
module fsp_timing #(
  parameter int CLK_HALF    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SLOT        = 9,
  localparam int DW = $clog2(CLK_HALF + 1),
  localparam int SW = $clog2(SLOT)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic run,
  input  logic sclk_in,
  input  logic rxd_in,
  input  logic txfs_in,
  input  logic rxfs_in,
  output logic sclk_out,
  output logic frame_out,
  output logic rise,
  output logic fall,
  output logic rxd_s,
  output logic txfs_e,
  output logic rxfs_e
);
  // resynchronisers: {clock, data, tx strobe, rx strobe}
  logic [SYNC_STAGES-1:0][3:0] sync_q;
  logic [3:0] sync_out;
  logic       sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '0;
      sclk_prev <= 1'b0;
    end else begin
      sync_q    <= {sync_q[SYNC_STAGES-2:0], {sclk_in, rxd_in, txfs_in, rxfs_in}};
      sclk_prev <= sync_out[3];
    end
  end
  assign sync_out = sync_q[SYNC_STAGES-1];

  // master clock and frame generator
  logic [DW-1:0] div_cnt;
  logic [SW-1:0] slot;
  logic          sclk_q, frame_q, tick, gen_on;

  assign gen_on = master && run;
  assign tick   = gen_on && (div_cnt == DW'(CLK_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      sclk_q  <= 1'b0;
      slot    <= SW'(SLOT - 1);
      frame_q <= 1'b0;
    end else if (!gen_on) begin
      div_cnt <= '0;
      sclk_q  <= 1'b0;
      slot    <= SW'(SLOT - 1);
      frame_q <= 1'b0;
    end else if (tick) begin
      div_cnt <= '0;
      sclk_q  <= ~sclk_q;
      if (!sclk_q) begin
        slot    <= (slot == SW'(SLOT - 1)) ? '0 : slot + 1'b1;
        frame_q <= (slot == SW'(SLOT - 1));
      end
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  logic m_rise, m_fall, s_rise, s_fall;
  assign m_rise = tick && !sclk_q;
  assign m_fall = tick && sclk_q;
  assign s_rise = !master && run && sync_out[3] && !sclk_prev;
  assign s_fall = !master && run && !sync_out[3] && sclk_prev;

  assign rise      = m_rise || s_rise;
  assign fall      = m_fall || s_fall;
  assign sclk_out  = sclk_q;
  assign frame_out = frame_q;
  assign rxd_s     = sync_out[2];
  assign txfs_e    = master ? frame_q : sync_out[1];
  assign rxfs_e    = master ? frame_q : sync_out[0];
endmodule

// File: rtl/fsp_tx.sv
module fsp_tx
  import fsp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  rise,
  input  logic  fall,
  input  logic  fs,
  input  logic  q_empty,
  input  half_t q_head,
  output logic  pop,
  output logic  underrun,
  output logic  txd
);
  localparam int CW = $clog2(BYTE_W + 1);

  logic [CW-1:0] bits_left;
  byte_t         sh, lo;
  logic          have_lo, txd_q, load;

  assign load     = en && fall && fs && (bits_left == '0);
  assign pop      = load && !have_lo && !q_empty;
  assign underrun = load && !have_lo && q_empty;
  assign txd      = txd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_left <= '0;
      sh        <= '0;
      lo        <= '0;
      have_lo   <= 1'b0;
      txd_q     <= 1'b0;
    end else if (!en) begin
      bits_left <= '0;
      sh        <= '0;
      have_lo   <= 1'b0;
      txd_q     <= 1'b0;
    end else if (load) begin
      bits_left <= CW'(BYTE_W);
      if (have_lo) begin
        sh      <= lo;
        have_lo <= 1'b0;
      end else if (!q_empty) begin
        sh      <= q_head[HALF_W-1:BYTE_W];
        lo      <= q_head[BYTE_W-1:0];
        have_lo <= 1'b1;
      end else begin
        sh <= '0;
      end
    end else if (rise && (bits_left != '0)) begin
      txd_q     <= sh[BYTE_W-1];
      sh        <= {sh[BYTE_W-2:0], 1'b0};
      bits_left <= bits_left - 1'b1;
    end
  end
endmodule

// File: rtl/fsp_rx.sv
module fsp_rx
  import fsp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  fall,
  input  logic  fs,
  input  logic  rxd,
  input  logic  q_full,
  output logic  push,
  output half_t push_data,
  output logic  overrun
);
  localparam int CW = $clog2(BYTE_W + 1);

  logic [CW-1:0] bits_left;
  byte_t         sh, hi, byte_done;
  logic          have_hi, last;

  assign byte_done = {sh[BYTE_W-2:0], rxd};
  assign last      = en && fall && (bits_left == CW'(1));
  assign push      = last && have_hi && !q_full;
  assign overrun   = last && have_hi && q_full;
  assign push_data = {hi, byte_done};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_left <= '0;
      sh        <= '0;
      hi        <= '0;
      have_hi   <= 1'b0;
    end else if (!en) begin
      bits_left <= '0;
      have_hi   <= 1'b0;
    end else if (fall) begin
      if (bits_left != '0) begin
        sh        <= byte_done;
        bits_left <= bits_left - 1'b1;
        if (bits_left == CW'(1)) begin
          if (!have_hi) begin
            hi      <= byte_done;
            have_hi <= 1'b1;
          end else begin
            have_hi <= 1'b0;
          end
        end
      end else if (fs) begin
        bits_left <= CW'(BYTE_W);
      end
    end
  end
endmodule

// File: rtl/framed_serial_port.sv
module framed_serial_port
  import fsp_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int CLK_HALF    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_master,
  input  logic        cfg_tx_en,
  input  logic        cfg_rx_en,
  input  logic        tx_valid,
  output logic        tx_ready,
  input  logic [15:0] tx_data,
  output logic        rx_valid,
  input  logic        rx_ready,
  output logic [15:0] rx_data,
  input  logic        stat_rd,
  output logic        stat_underrun,
  output logic        stat_overrun,
  output logic        irq_tx,
  output logic        irq_rx,
  input  logic        sclk_in,
  output logic        sclk_out,
  output logic        sclk_oe,
  output logic        txd_out,
  input  logic        rxd_in,
  input  logic        txfs_in,
  output logic        txfs_out,
  output logic        txfs_oe,
  input  logic        rxfs_in,
  output logic        rxfs_out,
  output logic        rxfs_oe
);
  localparam int LW        = $clog2(DEPTH + 1);
  localparam int HALF_MARK = DEPTH / 2;

  logic rise, fall, rxd_s, txfs_e, rxfs_e, frame, run;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_pop, und_evt, rx_push, ovr_evt;
  logic [LW-1:0] tx_level, rx_level;
  half_t tx_head, rx_word, rx_head;
  logic und_q, ovr_q;

  assign run = cfg_tx_en || cfg_rx_en;

  fsp_timing #(
    .CLK_HALF(CLK_HALF), .SYNC_STAGES(SYNC_STAGES), .SLOT(SLOT_PERIODS)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .master(cfg_master), .run(run),
    .sclk_in(sclk_in), .rxd_in(rxd_in), .txfs_in(txfs_in), .rxfs_in(rxfs_in),
    .sclk_out(sclk_out), .frame_out(frame), .rise(rise), .fall(fall),
    .rxd_s(rxd_s), .txfs_e(txfs_e), .rxfs_e(rxfs_e)
  );

  fsp_fifo #(.W(HALF_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_valid), .push_data(tx_data),
    .pop(tx_pop), .head(tx_head), .full(tx_full), .empty(tx_empty),
    .level(tx_level)
  );

  fsp_fifo #(.W(HALF_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(rx_word),
    .pop(rx_ready), .head(rx_head), .full(rx_full), .empty(rx_empty),
    .level(rx_level)
  );

  fsp_tx u_tx (
    .clk(clk), .rst_n(rst_n), .en(cfg_tx_en), .rise(rise), .fall(fall),
    .fs(txfs_e), .q_empty(tx_empty), .q_head(tx_head), .pop(tx_pop),
    .underrun(und_evt), .txd(txd_out)
  );

  fsp_rx u_rx (
    .clk(clk), .rst_n(rst_n), .en(cfg_rx_en), .fall(fall), .fs(rxfs_e),
    .rxd(rxd_s), .q_full(rx_full), .push(rx_push), .push_data(rx_word),
    .overrun(ovr_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      und_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      und_q <= (und_q && !stat_rd) || und_evt;
      ovr_q <= (ovr_q && !stat_rd) || ovr_evt;
    end
  end

  assign tx_ready      = !tx_full;
  assign rx_valid      = !rx_empty;
  assign rx_data       = rx_head;
  assign stat_underrun = und_q;
  assign stat_overrun  = ovr_q;
  assign irq_tx        = cfg_tx_en && (tx_level <= LW'(HALF_MARK));
  assign irq_rx        = cfg_rx_en && (rx_level >= LW'(HALF_MARK));
  assign sclk_oe       = cfg_master;
  assign txfs_oe       = cfg_master;
  assign rxfs_oe       = cfg_master;
  assign txfs_out      = frame;
  assign rxfs_out      = frame;
endmodule

// File: rtl/fsp_checker.sv
module fsp_checker #(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_tx_en,
  input logic          cfg_rx_en,
  input logic          sclk_out,
  input logic          tx_ready,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          tx_pop,
  input logic          rx_push,
  input logic          stat_rd,
  input logic          stat_underrun,
  input logic          ovr_evt,
  input logic          stat_overrun
);
  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_tx_en && !cfg_rx_en) |=> !sclk_out);

  assert_tx_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= LW'(DEPTH));

  assert_full_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == LW'(DEPTH)) |-> !tx_ready);

  assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> (tx_level != '0));

  assert_no_push_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> (rx_level < LW'(DEPTH)));

  assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_underrun && !stat_rd) |=> stat_underrun);

  assert_overrun_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ovr_evt) |=> !stat_overrun);
endmodule

bind framed_serial_port fsp_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en),
  .sclk_out(sclk_out), .tx_ready(tx_ready), .tx_level(tx_level),
  .rx_level(rx_level), .tx_pop(tx_pop), .rx_push(rx_push),
  .stat_rd(stat_rd), .stat_underrun(stat_underrun), .ovr_evt(ovr_evt),
  .stat_overrun(stat_overrun)
);

// File: tb/framed_serial_port_tb.sv
module framed_serial_port_tb;
  localparam int HALF  = 4;
  localparam int SH    = 20;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_master = 1'b0, cfg_tx_en = 1'b0, cfg_rx_en = 1'b0;
  logic tx_valid = 1'b0, rx_ready = 1'b0, stat_rd = 1'b0;
  logic [15:0] tx_data = '0;
  logic s_sclk = 1'b0, s_rxd = 1'b0, s_tfs = 1'b0, s_rfs = 1'b0;
  logic tx_ready, rx_valid, stat_underrun, stat_overrun, irq_tx, irq_rx;
  logic [15:0] rx_data;
  logic sclk_out, sclk_oe, txd_out, txfs_out, txfs_oe, rxfs_out, rxfs_oe;
  logic rxd_w;

  always #5 clk = ~clk;
  assign rxd_w = cfg_master ? txd_out : s_rxd;

  framed_serial_port #(.DEPTH(DEPTH), .CLK_HALF(HALF), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_tx_en(cfg_tx_en),
    .cfg_rx_en(cfg_rx_en), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .stat_rd(stat_rd), .stat_underrun(stat_underrun),
    .stat_overrun(stat_overrun), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .sclk_in(s_sclk), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .txd_out(txd_out), .rxd_in(rxd_w), .txfs_in(s_tfs), .txfs_out(txfs_out),
    .txfs_oe(txfs_oe), .rxfs_in(s_rfs), .rxfs_out(rxfs_out), .rxfs_oe(rxfs_oe)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0]  exp_b[$];
  logic [15:0] exp_w[$];
  bit mon_en = 1'b0, rd_mon = 1'b0, done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: push one word into the transmit stream
  task automatic push_word(input logic [15:0] w, input bit track);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = w;
    if (track) begin
      exp_b.push_back(w[15:8]);
      exp_b.push_back(w[7:0]);
      exp_w.push_back(w);
    end
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic read_status();
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
  endtask

  // bench as far-end clock master: one framed byte in both directions
  task automatic sbyte(input logic [7:0] din, output logic [7:0] dout);
    s_tfs = 1'b1; s_rfs = 1'b1;
    repeat (SH) @(negedge clk);
    s_sclk = 1'b1;
    repeat (SH) @(negedge clk);
    s_sclk = 1'b0;
    repeat (SH) @(negedge clk);
    s_tfs = 1'b0; s_rfs = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      s_rxd  = din[i];
      s_sclk = 1'b1;
      repeat (SH) @(negedge clk);
      dout[i] = txd_out;
      s_sclk  = 1'b0;
      repeat (SH) @(negedge clk);
    end
  endtask

  // monitor: decode the master serial stream and compare with the queue
  int cyc = 1, last_rise = 0, m_bits = 0;
  logic [7:0] m_sh = '0;
  logic sc_prev = 1'b0;
  always @(negedge clk) begin
    if (mon_en) begin
      if (sclk_out && !sc_prev) begin
        if (last_rise != 0) chk("R2 clock period", cyc - last_rise, 2 * HALF);
        last_rise = cyc;
      end
      if (!sclk_out && sc_prev) begin
        if (m_bits == 0) begin
          if (txfs_out) begin m_bits = 8; m_sh = '0; end
        end else begin
          if (m_bits == 8) chk("R3 strobe one period", {31'd0, txfs_out}, 0);
          m_sh = {m_sh[6:0], txd_out};
          m_bits--;
          if (m_bits == 0) begin
            if (exp_b.size() != 0) chk("R3 byte order", {24'd0, m_sh}, {24'd0, exp_b.pop_front()});
            else                   chk("R5 underrun zero", {24'd0, m_sh}, 0);
          end
        end
      end
    end else begin
      m_bits = 0;
      last_rise = 0;
    end
    sc_prev = sclk_out;
    cyc++;
  end

  // monitor: receive stream in loopback
  always @(negedge clk) begin
    if (rd_mon && rx_valid && rx_ready) begin
      if (exp_w.size() != 0) chk("R4 loopback word", {16'd0, rx_data}, {16'd0, exp_w.pop_front()});
      else                   chk("R4 trailing zero word", {16'd0, rx_data}, 0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    logic [15:0] tw [16];
    logic [15:0] rw [16];
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R12 reset ready", {31'd0, tx_ready}, 1);
    chk("R11 reset rx empty", {31'd0, rx_valid}, 0);
    chk("R7 reset flags", {30'd0, stat_underrun, stat_overrun}, 0);
    chk("R8 irq off when disabled", {31'd0, irq_tx}, 0);
    chk("R1 slave oe", {29'd0, sclk_oe, txfs_oe, rxfs_oe}, 0);

    // ---------------- master loopback ----------------
    cfg_master = 1'b1;
    @(negedge clk);
    chk("R1 master oe", {29'd0, sclk_oe, txfs_oe, rxfs_oe}, 3'b111);
    push_word(16'hA55A, 1'b1);
    push_word(16'h1234, 1'b1);
    push_word(16'hFF00, 1'b1);
    push_word(16'h8001, 1'b1);
    repeat (100) @(negedge clk);
    chk("R2 idle clock", {31'd0, sclk_out}, 0);
    chk("R11 tx disabled line low", {31'd0, txd_out}, 0);
    chk("R11 rx disabled nothing stored", {31'd0, rx_valid}, 0);
    mon_en = 1'b1; rd_mon = 1'b1; rx_ready = 1'b1;
    cfg_tx_en = 1'b1; cfg_rx_en = 1'b1;
    repeat (1600) @(negedge clk);
    mon_en = 1'b0;
    cfg_tx_en = 1'b0; cfg_rx_en = 1'b0;
    repeat (40) @(negedge clk);
    rd_mon = 1'b0; rx_ready = 1'b0;
    chk("R4 all words returned", exp_w.size(), 0);
    chk("R3 all bytes seen", exp_b.size(), 0);
    chk("R5 underrun flag", {31'd0, stat_underrun}, 1);
    chk("R2 clock stops", {31'd0, sclk_out}, 0);
    read_status();
    chk("R7 underrun cleared", {31'd0, stat_underrun}, 0);

    // ---------------- overrun via loopback ----------------
    cfg_rx_en = 1'b1;
    repeat (3000) @(negedge clk);
    chk("R11 tx off no underrun", {31'd0, stat_underrun}, 0);
    chk("R11 tx off line low", {31'd0, txd_out}, 0);
    chk("R6 overrun flag", {31'd0, stat_overrun}, 1);
    chk("R9 irq_rx high", {31'd0, irq_rx}, 1);
    cfg_rx_en = 1'b0;
    @(negedge clk);
    chk("R9 irq_rx gated", {31'd0, irq_rx}, 0);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      chk("R6 stored word present", {31'd0, rx_valid}, 1);
      chk("R6 stored word value", {16'd0, rx_data}, 0);
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
    end
    @(negedge clk);
    chk("R6 exactly sixteen kept", {31'd0, rx_valid}, 0);
    read_status();
    chk("R7 overrun cleared", {31'd0, stat_overrun}, 0);

    // ---------------- slave mode ----------------
    cfg_master = 1'b0;
    cfg_tx_en = 1'b1; cfg_rx_en = 1'b1;
    @(negedge clk);
    chk("R1 slave oe again", {29'd0, sclk_oe, txfs_oe, rxfs_oe}, 0);
    chk("R8 irq_tx empty", {31'd0, irq_tx}, 1);
    for (int i = 0; i < DEPTH; i++) begin
      tw[i] = 16'h3C00 + 16'(i * 16'h0111);
      rw[i] = 16'hC3A5 ^ 16'(i * 16'h0907);
      push_word(tw[i], 1'b0);
      chk("R8 irq_tx level", {31'd0, irq_tx}, (i + 1 <= DEPTH / 2) ? 1 : 0);
    end
    chk("R12 full not ready", {31'd0, tx_ready}, 0);
    tx_valid = 1'b1; tx_data = 16'hDEAD;
    repeat (3) @(negedge clk);
    tx_valid = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      sbyte(rw[i][15:8], got);
      chk("R10 slave tx high byte", {24'd0, got}, {24'd0, tw[i][15:8]});
      sbyte(rw[i][7:0], got);
      chk("R10 slave tx low byte", {24'd0, got}, {24'd0, tw[i][7:0]});
      repeat (4) @(negedge clk);
      chk("R9 irq_rx level", {31'd0, irq_rx}, (i + 1 >= DEPTH / 2) ? 1 : 0);
    end
    chk("R5 no underrun yet", {31'd0, stat_underrun}, 0);
    sbyte(8'h77, got);
    chk("R12 rejected write absent", {24'd0, got}, 0);
    sbyte(8'h88, got);
    chk("R5 slave underrun zero", {24'd0, got}, 0);
    repeat (4) @(negedge clk);
    chk("R5 slave underrun flag", {31'd0, stat_underrun}, 1);
    chk("R6 slave overrun flag", {31'd0, stat_overrun}, 1);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      chk("R10 slave rx word", {16'd0, rx_data}, {16'd0, rw[i]});
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
    end
    @(negedge clk);
    chk("R6 dropped word not stored", {31'd0, rx_valid}, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule